// File: doc/BRIEF.md
# 104-bit Word Lane Serializer with Loopback Deserializer

This block carries one wide word per sensor period from a camera data path to a companion device over thirteen serial lanes. On every sensor period it takes ten 10-bit pixels plus the line-valid and frame-valid flags and packs them into a 104-bit word. The two spare bits of that word are zero. It then cuts the word into thirteen 8-bit slices and shifts each slice out on its own lane, one bit per fast clock, so that a whole word leaves in eight fast clocks.

A word mark travels beside the lanes and is high during the first bit slot of each word. A matching receiver uses that mark to find word boundaries, rebuilds the 104-bit word and signals it with a one-cycle valid pulse.

The design runs on the fast clock alone. The sensor period is a free-running count of eight fast clocks. A take strobe marks the fast cycle whose closing edge samples the parallel inputs, and that edge is the sensor clock edge.

Top module: `lane_serdes13`

## Requirements
- R1: The packed word places pixel i at bits [10i+9:10i]. Line-valid is bit 100, frame-valid is bit 101, and bits [103:102] are always 0.
- R2: Lane k carries word bits [8k+7:8k]. The most significant bit goes first, one bit per fast clock, starting in the cycle where `tx_mark` is high.
- R3: `tx_take` is high in exactly one of every eight fast cycles. The parallel inputs are sampled at the rising edge that ends that cycle, including the first such edge after reset.
- R4: `tx_mark` is high for exactly one fast cycle per word, namely the cycle that follows the sampling edge, and never in two consecutive cycles.
- R5: The receiver delivers the word bit-exact on `rx_word`. `rx_valid` is a single-cycle pulse that rises at the rising edge that samples the eighth bit slot, which is eight fast clocks after the transmit sampling edge.
- R6: Words pass back to back, one every eight fast clocks, with no gap, loss, reordering or duplication.
- R7: While reset is low, `tx_lanes`, `tx_mark`, `rx_valid` and `rx_word` are all 0.
- R8: The receiver ignores lane activity that is not preceded by a high `rx_mark`, and raises no `rx_valid` for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock, eight per sensor period |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_pix | input | 100 | Ten pixels, pixel i in bits [10i+9:10i] |
| tx_lval | input | 1 | Line-valid flag for the word |
| tx_fval | input | 1 | Frame-valid flag for the word |
| tx_take | output | 1 | High in the cycle whose closing edge samples the inputs |
| tx_lanes | output | 13 | Serial lane outputs |
| tx_mark | output | 1 | High during the first bit slot of each word |
| rx_lanes | input | 13 | Serial lane inputs to the receiver |
| rx_mark | input | 1 | Word mark input to the receiver |
| rx_word | output | 104 | Last reassembled word |
| rx_word_valid | output | 1 | One-cycle pulse when a new word is on `rx_word` |

## Verification
The bench builds the block with its default parameters: ten 10-bit pixels, thirteen lanes and eight slots. At these values the word width is exactly 104 bits with two spare bits, and every lane offset and the eight-slot cadence the requirements name can be observed directly. Loopback lets every streamed word be compared end to end with an exact arrival cycle. Switching loopback off lets unmarked lane noise reach the receiver by itself.

// File: rtl/lane_serdes13.sv
module lane_serdes13 #(
  parameter int NPIX  = 10,
  parameter int PIXW  = 10,
  parameter int LANES = 13,
  parameter int SLOTS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPIX*PIXW-1:0]    tx_pix,
  input  logic                    tx_lval,
  input  logic                    tx_fval,
  output logic                    tx_take,
  output logic [LANES-1:0]        tx_lanes,
  output logic                    tx_mark,
  input  logic [LANES-1:0]        rx_lanes,
  input  logic                    rx_mark,
  output logic [LANES*SLOTS-1:0]  rx_word,
  output logic                    rx_word_valid
);
  localparam int WORD  = LANES * SLOTS;
  localparam int SPARE = WORD - NPIX * PIXW - 2;
  localparam int PW    = $clog2(SLOTS);
  localparam logic [PW-1:0] LAST = PW'(SLOTS - 1);

  logic [WORD-1:0] tx_word;
  logic [PW-1:0]   ph;
  logic [PW-1:0]   rcnt;
  logic            armed;
  logic            done;

  assign tx_word = {{SPARE{1'b0}}, tx_fval, tx_lval, tx_pix};
  assign tx_take = (ph == LAST);
  assign done    = armed && !rx_mark && (rcnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= LAST;
      tx_mark <= 1'b0;
    end else begin
      ph      <= tx_take ? '0 : ph + 1'b1;
      tx_mark <= tx_take;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed         <= 1'b0;
      rcnt          <= '0;
      rx_word_valid <= 1'b0;
    end else begin
      rx_word_valid <= done;
      if (rx_mark) begin
        armed <= 1'b1;
        rcnt  <= PW'(1);
      end else if (armed) begin
        rcnt <= rcnt + 1'b1;
        if (done) armed <= 1'b0;
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SLOTS-1:0] tsh;
    logic [SLOTS-2:0] rsh;
    logic [SLOTS-1:0] rcap;

    always_ff @(posedge clk) begin
      if (!rst_n)       tsh <= '0;
      else if (tx_take) tsh <= tx_word[k*SLOTS +: SLOTS];
      else              tsh <= tsh << 1;
    end
    assign tx_lanes[k] = tsh[SLOTS-1];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rsh  <= '0;
        rcap <= '0;
      end else begin
        if (rx_mark || armed) rsh <= {rsh[SLOTS-3:0], rx_lanes[k]};
        if (done) rcap <= {rsh, rx_lanes[k]};
      end
    end
    assign rx_word[k*SLOTS +: SLOTS] = rcap;
  end

  assert_mark_after_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> tx_mark);
  assert_mark_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mark |=> !tx_mark);
  assert_take_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> !tx_take);
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word_valid |=> !rx_word_valid);
  assert_mark_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mark |=> !rx_word_valid);
endmodule

// File: tb/lane_serdes13_bench.sv
module lane_serdes13_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [99:0]  tx_pix = '0;
  logic         tx_lval = 1'b0, tx_fval = 1'b0;
  logic         tx_take, tx_mark;
  logic [12:0]  tx_lanes;
  logic [12:0]  drv_lanes = '0;
  logic         drv_mark = 1'b0;
  logic         loop = 1'b0;
  logic [12:0]  rx_lanes;
  logic         rx_mark;
  logic [103:0] rx_word;
  logic         rx_word_valid;

  int checks = 0, fails = 0;
  int cyc = 0;
  logic [103:0] exp_w [0:1023];
  int           exp_c [0:1023];
  int wr = 0, rd = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign rx_lanes = loop ? tx_lanes : drv_lanes;
  assign rx_mark  = loop ? tx_mark  : drv_mark;

  lane_serdes13 u_lane_serdes13 (
    .clk(clk), .rst_n(rst_n), .tx_pix(tx_pix), .tx_lval(tx_lval), .tx_fval(tx_fval),
    .tx_take(tx_take), .tx_lanes(tx_lanes), .tx_mark(tx_mark),
    .rx_lanes(rx_lanes), .rx_mark(rx_mark), .rx_word(rx_word), .rx_word_valid(rx_word_valid)
  );

  function automatic logic [103:0] pack(logic [99:0] p, logic lv, logic fv);
    logic [103:0] w;
    w = '0;
    for (int i = 0; i < 10; i++) w[10*i +: 10] = p[10*i +: 10];
    w[100] = lv;
    w[101] = fv;
    return w;
  endfunction

  task automatic check(bit ok, string req, logic [103:0] act, logic [103:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (loop && tx_take && wr < 1024) begin
        exp_w[wr] = pack(tx_pix, tx_lval, tx_fval);
        exp_c[wr] = cyc + 9;
        wr++;
      end
      if (rx_word_valid) begin
        if (!loop) check(1'b0, "R8 unmarked lane data gave a word", {103'd0, rx_word_valid}, 104'd0);
        else if (rd >= wr) check(1'b0, "R6 extra word", rx_word, 104'd0);
        else begin
          check(rx_word === exp_w[rd], "R1/R5 word", rx_word, exp_w[rd]);
          check(cyc == exp_c[rd], "R5/R6 arrival cycle", 104'(cyc), 104'(exp_c[rd]));
          rd++;
        end
      end
    end
  end

  task automatic do_reset(logic lp);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    loop = lp;
    wr = 0;
    rd = 0;
    rst_n = 1'b1;
  endtask

  task automatic wait_take();
    do @(negedge clk); while (!tx_take);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check(tx_lanes === 13'd0, "R7 lanes", 104'(tx_lanes), 104'd0);
    check(tx_mark === 1'b0, "R7 mark", 104'(tx_mark), 104'd0);
    check(rx_word_valid === 1'b0, "R7 valid", 104'(rx_word_valid), 104'd0);
    check(rx_word === 104'd0, "R7 word", rx_word, 104'd0);
  endtask

  task automatic t_ignore_unmarked();
    do_reset(1'b0);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      drv_lanes = 13'($urandom);
      drv_mark = 1'b0;
    end
    @(negedge clk);
    check(rx_word_valid === 1'b0, "R8 no valid", 104'(rx_word_valid), 104'd0);
    check(rx_word === 104'd0, "R8 word untouched", rx_word, 104'd0);
  endtask

  task automatic t_patterns();
    logic [99:0] p;
    for (int n = 0; n < 6; n++) begin
      wait_take();
      case (n)
        0: p = '0;
        1: p = '1;
        2: for (int i = 0; i < 10; i++) p[10*i +: 10] = 10'(i + 1);
        3: p = {50{2'b10}};
        default: p = {$urandom, $urandom, $urandom, 4'($urandom)};
      endcase
      tx_pix = p;
      tx_lval = n[0];
      tx_fval = n[1];
    end
    repeat (20) @(negedge clk);
    check(rd + 2 >= wr, "R6 patterns delivered", 104'(rd), 104'(wr));
  endtask

  task automatic t_lane_order();
    logic [103:0] w;
    logic [12:0] e;
    wait_take();
    tx_pix = {$urandom, $urandom, $urandom, 4'($urandom)};
    tx_lval = 1'b1;
    tx_fval = 1'b0;
    w = pack(tx_pix, 1'b1, 1'b0);
    @(negedge clk);
    check(tx_mark === 1'b1, "R4 mark in first slot", 104'(tx_mark), 104'd1);
    for (int j = 0; j < 8; j++) begin
      for (int k = 0; k < 13; k++) e[k] = w[8*k + 7 - j];
      check(tx_lanes === e, "R2 lane bits", 104'(tx_lanes), 104'(e));
      @(negedge clk);
    end
  endtask

  task automatic t_cadence();
    int takes = 0, marks = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      takes += int'(tx_take);
      marks += int'(tx_mark);
    end
    check(takes == 8, "R3 take cadence", 104'(takes), 104'd8);
    check(marks == 8, "R4 mark cadence", 104'(marks), 104'd8);
  endtask

  task automatic t_burst();
    int r0;
    r0 = rd;
    for (int n = 0; n < 40; n++) begin
      wait_take();
      tx_pix = {$urandom, $urandom, $urandom, 4'($urandom)};
      tx_lval = 1'($urandom);
      tx_fval = 1'($urandom);
    end
    repeat (20) @(negedge clk);
    check(rd - r0 >= 40, "R6 burst count", 104'(rd - r0), 104'd40);
    check(rd + 2 >= wr, "R6 no loss", 104'(rd), 104'(wr));
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset_state();
    t_ignore_unmarked();
    do_reset(1'b1);
    t_patterns();
    t_lane_order();
    t_cadence();
    t_burst();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule